// File: doc/BRIEF.md
# Iterative TEA Block Cipher Core

This block runs the Tiny Encryption Algorithm on a single 64-bit block under a 128-bit key, in either direction. The cipher is a Feistel network whose round mixes one 32-bit half with two key words and a running multiple of the golden-ratio constant 32'h9E3779B9, using only shifts, 32-bit additions and XOR. The core performs one complete cycle, both half-updates, per clock. A full operation therefore takes 32 clocks. The running sum is held in a register inside the core.

A host presents the key, the data block and the direction bit, then raises `start_i` for one clock while the core is idle. The core copies all three into internal registers on that edge and steps through 32 cycles. It then raises `done_o` for one clock. The result remains on `result_o` until the next accepted start.

The control is a two-state machine:
- ST_IDLE waits. The transition *accept* (start seen while idle) loads the operands and moves to ST_RUN.
- ST_RUN steps the datapath once per clock. The transition *advance* stays in ST_RUN and bumps the cycle counter.
- The transition *finish* (last cycle) returns to ST_IDLE and fires the done pulse.

Top module: `tea_core`

## Requirements
- R1: While reset is asserted and after its release, `result_o` is zero and `done_o` is low until the first operation completes.
- R2: With `decrypt_i`=0, the result is TEA encryption of `data_i` with 32 cycles, as described below.
  - The first half is `data_i[63:32]` and the second half is `data_i[31:0]`.
  - The key words are K0=`key_i[127:96]`, K1=`key_i[95:64]`, K2=`key_i[63:32]` and K3=`key_i[31:0]`.
  - In each cycle, sum is first increased by 32'h9E3779B9.
  - The first half is then increased by F(second, K0, K1, sum).
  - The second half is then increased by F(new first, K2, K3, sum).
  - F(x,a,b,s) = ((x<<4)+a) ^ (x+s) ^ ((x>>5)+b), with all additions taken modulo 2^32.
  - The result places the first half in bits [63:32].
- R3: With `decrypt_i`=1, the core inverts R2, as described below.
  - Sum starts at 32'hC6EF3720.
  - In each cycle, the second half is decreased by F(first, K2, K3, sum).
  - The first half is then decreased by F(new second, K0, K1, sum).
  - Sum is then decreased by 32'h9E3779B9.
  - Decrypting a ciphertext with the same key returns the plaintext.
- R4: An all-zero key and all-zero data block encrypt to 64'h41EA3A0A_94BAA940.
- R5: `done_o` is high for exactly one clock. It rises on the 33rd rising edge counted from the edge that samples `start_i` high (the sampling edge plus 32 stepping edges).
- R6: Key, data and direction are captured at the accepting edge. Later changes to `key_i`, `data_i` or `decrypt_i` during the operation do not alter the result.
- R7: A `start_i` pulse while an operation is running is ignored. The running operation keeps its operands and its completion time.
- R8: While idle and without a start, `result_o` holds its value regardless of the other inputs.
- R9: The right shift in F is logical and fills with zeros, which matters for halves whose bit 31 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-clock request to begin an operation |
| decrypt_i | input | 1 | 0 = encrypt, 1 = decrypt |
| data_i | input | 64 | Input block, first half in [63:32] |
| key_i | input | 128 | Key, K0 in [127:96] down to K3 in [31:0] |
| result_o | output | 64 | Output block, first half in [63:32] |
| done_o | output | 1 | One-clock completion pulse |

## Verification
The cipher is tried with the following inputs:
- The all-zero key and block. Their fixed known answer separates a correct round order and sum timing from plausible variants, such as incrementing sum after use.
- Keys and blocks with top bits set, including all-ones. These tell a logical right shift from an arithmetic one, and expose a carry that is mishandled in the 32-bit additions.
- Each ciphertext decrypted again. This distinguishes a true inverse (reverse half order, preset sum, post-decrement) from an inverse with the wrong key-pair assignment.
- Operand changes and extra start pulses during a run. These show whether the operands are really latched and whether the run ignores them.

// File: rtl/tea_pkg.sv
package tea_pkg;

    localparam int unsigned HALF_W   = 32;
    localparam int unsigned BLOCK_W  = 2 * HALF_W;
    localparam int unsigned KEY_W    = 4 * HALF_W;
    localparam int unsigned SHIFT_L  = 4;
    localparam int unsigned SHIFT_R  = 5;
    localparam logic [HALF_W-1:0] GOLDEN = 32'h9E37_79B9;

    typedef logic [HALF_W-1:0] half_t;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } tea_state_e;

endpackage

// File: rtl/tea_mix.sv
// Round function: ((x << L) + ka) ^ (x + s) ^ ((x >> R) + kb), modulo 2^W.
module tea_mix
    import tea_pkg::*;
(
    input  half_t x_i,
    input  half_t ka_i,
    input  half_t kb_i,
    input  half_t sum_i,
    output half_t f_o
);
    half_t lo_term;
    half_t mid_term;
    half_t hi_term;

    always_comb begin
        lo_term  = (x_i << SHIFT_L) + ka_i;
        mid_term = x_i + sum_i;
        hi_term  = (x_i >> SHIFT_R) + kb_i;   // logical, zero fill
        f_o      = lo_term ^ mid_term ^ hi_term;
    end
endmodule

// File: rtl/tea_step.sv
// One full cipher cycle (two half updates) in either direction.
module tea_step
    import tea_pkg::*;
(
    input  logic  decrypt_i,
    input  half_t first_i,
    input  half_t second_i,
    input  half_t k0_i,
    input  half_t k1_i,
    input  half_t k2_i,
    input  half_t k3_i,
    input  half_t sum_i,
    output half_t first_o,
    output half_t second_o
);
    half_t src_a, tgt_a, ka_a, kb_a, f_a, upd_a;
    half_t tgt_b, ka_b, kb_b, f_b, upd_b;

    // encrypt: first += F(second,K0,K1); second += F(first',K2,K3)
    // decrypt: second -= F(first,K2,K3); first -= F(second',K0,K1)
    always_comb begin
        src_a = decrypt_i ? first_i  : second_i;
        tgt_a = decrypt_i ? second_i : first_i;
        ka_a  = decrypt_i ? k2_i     : k0_i;
        kb_a  = decrypt_i ? k3_i     : k1_i;
        tgt_b = decrypt_i ? first_i  : second_i;
        ka_b  = decrypt_i ? k0_i     : k2_i;
        kb_b  = decrypt_i ? k1_i     : k3_i;
    end

    tea_mix u_mix_a (
        .x_i  (src_a),
        .ka_i (ka_a),
        .kb_i (kb_a),
        .sum_i(sum_i),
        .f_o  (f_a)
    );

    assign upd_a = decrypt_i ? (tgt_a - f_a) : (tgt_a + f_a);

    tea_mix u_mix_b (
        .x_i  (upd_a),
        .ka_i (ka_b),
        .kb_i (kb_b),
        .sum_i(sum_i),
        .f_o  (f_b)
    );

    assign upd_b = decrypt_i ? (tgt_b - f_b) : (tgt_b + f_b);

    always_comb begin
        first_o  = decrypt_i ? upd_b : upd_a;
        second_o = decrypt_i ? upd_a : upd_b;
    end
endmodule

// File: rtl/tea_ctrl.sv
// Sequencer: idle / run state machine with a cycle counter.
module tea_ctrl
    import tea_pkg::*;
#(
    parameter int unsigned ROUNDS = 32,
    localparam int unsigned CNT_W = (ROUNDS > 1) ? $clog2(ROUNDS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    output tea_state_e       state_o,
    output logic [CNT_W-1:0] rnd_o,
    output logic             load_o,
    output logic             step_o,
    output logic             done_o
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(ROUNDS - 1);

    tea_state_e       state_q, state_d;
    logic [CNT_W-1:0] rnd_q;
    logic             last_w;
    logic             done_q;

    assign last_w = (rnd_q == LAST);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i) state_d = ST_RUN;     // accept
            ST_RUN:  if (last_w)  state_d = ST_IDLE;    // finish, else advance
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                rnd_q <= '0;
        else if (state_q == ST_IDLE) rnd_q <= '0;
        else if (!last_w)          rnd_q <= rnd_q + 1'b1;
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= (state_q == ST_RUN) && last_w;
    end

    assign load_o  = (state_q == ST_IDLE) && start_i;
    assign step_o  = (state_q == ST_RUN);
    assign state_o = state_q;
    assign rnd_o   = rnd_q;
    assign done_o  = done_q;
endmodule

// File: rtl/tea_core.sv
module tea_core
    import tea_pkg::*;
#(
    parameter int unsigned ROUNDS = 32,
    localparam int unsigned CNT_W = (ROUNDS > 1) ? $clog2(ROUNDS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               decrypt_i,
    input  logic [BLOCK_W-1:0] data_i,
    input  logic [KEY_W-1:0]   key_i,
    output logic [BLOCK_W-1:0] result_o,
    output logic               done_o
);
    localparam half_t SUM_END = half_t'(ROUNDS * GOLDEN);

    tea_state_e       state_w;
    logic [CNT_W-1:0] rnd_w;
    logic             load_w, step_w;

    half_t            first_q, second_q, sum_q;
    half_t            kw_q [4];
    logic             mode_q;
    half_t            sum_use, sum_nxt, first_nxt, second_nxt;

    tea_ctrl #(.ROUNDS(ROUNDS)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_i(start_i),
        .state_o(state_w),
        .rnd_o  (rnd_w),
        .load_o (load_w),
        .step_o (step_w),
        .done_o (done_o)
    );

    // encrypt adds before use; decrypt uses then subtracts
    always_comb begin
        sum_use = mode_q ? sum_q : (sum_q + GOLDEN);
        sum_nxt = mode_q ? (sum_q - GOLDEN) : sum_use;
    end

    tea_step u_step (
        .decrypt_i(mode_q),
        .first_i  (first_q),
        .second_i (second_q),
        .k0_i     (kw_q[0]),
        .k1_i     (kw_q[1]),
        .k2_i     (kw_q[2]),
        .k3_i     (kw_q[3]),
        .sum_i    (sum_use),
        .first_o  (first_nxt),
        .second_o (second_nxt)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_q  <= '0;
            second_q <= '0;
            sum_q    <= '0;
            mode_q   <= 1'b0;
        end else if (load_w) begin
            first_q  <= data_i[BLOCK_W-1:HALF_W];
            second_q <= data_i[HALF_W-1:0];
            sum_q    <= decrypt_i ? SUM_END : '0;
            mode_q   <= decrypt_i;
        end else if (step_w) begin
            first_q  <= first_nxt;
            second_q <= second_nxt;
            sum_q    <= sum_nxt;
        end
    end

    // K0 sits in the top word of the key
    for (genvar g = 0; g < 4; g++) begin : g_key
        always_ff @(posedge clk) begin
            if (!rst_n)      kw_q[g] <= '0;
            else if (load_w) kw_q[g] <= key_i[KEY_W-1-g*HALF_W -: HALF_W];
        end
    end

    assign result_o = {first_q, second_q};
endmodule

// File: rtl/tea_core_chk.sv
module tea_core_chk
    import tea_pkg::*;
#(
    parameter int unsigned ROUNDS = 32,
    localparam int unsigned CNT_W = (ROUNDS > 1) ? $clog2(ROUNDS) : 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start_i,
    input logic               done_o,
    input logic [BLOCK_W-1:0] result_o,
    input tea_state_e         state,
    input logic [CNT_W-1:0]   rnd,
    input logic               mode,
    input half_t              sum
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(ROUNDS - 1);
    localparam half_t SUM_END = half_t'(ROUNDS * GOLDEN);

    // R5
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R5
    done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(state) == ST_RUN && $past(rnd) == LAST && state == ST_IDLE));

    // R7
    run_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && rnd != LAST) |=> (state == ST_RUN && rnd == $past(rnd) + 1'b1));

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !start_i) |=> $stable(result_o));

    // R2
    enc_sum_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !mode) |-> sum == SUM_END);

    // R3
    dec_sum_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && mode) |-> sum == '0);
endmodule

bind tea_core tea_core_chk #(.ROUNDS(ROUNDS)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .done_o  (done_o),
    .result_o(result_o),
    .state   (state_w),
    .rnd     (rnd_w),
    .mode    (mode_q),
    .sum     (sum_q)
);

// File: tb/tea_core_tb_top.sv
module tea_core_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int N_VEC      = 6;
    localparam int EXP_LAT    = 33;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic         decrypt_i = 1'b0;
    logic [63:0]  data_i = '0;
    logic [127:0] key_i = '0;
    logic [63:0]  result_o;
    logic         done_o;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tea_core dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .decrypt_i(decrypt_i),
        .data_i(data_i), .key_i(key_i), .result_o(result_o), .done_o(done_o)
    );

    localparam logic [127:0] TV_KEY [N_VEC] = '{
        128'h0,
        128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210,
        128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF,
        128'h8000_0000_0000_0001_7FFF_FFFF_DEAD_BEEF,
        128'h1111_2222_3333_4444_5555_6666_7777_8888,
        128'hA5A5_A5A5_5A5A_5A5A_C3C3_C3C3_3C3C_3C3C
    };
    localparam logic [63:0] TV_DATA [N_VEC] = '{
        64'h0000_0000_0000_0001,
        64'h0123_4567_89AB_CDEF,
        64'hFFFF_FFFF_FFFF_FFFF,
        64'h8000_0000_8000_0000,
        64'hCAFE_F00D_1234_5678,
        64'hF0E1_D2C3_B4A5_9687
    };
    localparam logic TV_DEC [N_VEC] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0};

    function automatic logic [31:0] ref_f(logic [31:0] x, logic [31:0] a,
                                          logic [31:0] b, logic [31:0] s);
        return ((x << 4) + a) ^ (x + s) ^ ((x >> 5) + b);
    endfunction

    function automatic logic [63:0] ref_enc(logic [63:0] d, logic [127:0] k);
        logic [31:0] y, z, s;
        y = d[63:32]; z = d[31:0]; s = '0;
        for (int i = 0; i < 32; i++) begin
            s = s + 32'h9E37_79B9;
            y = y + ref_f(z, k[127:96], k[95:64], s);
            z = z + ref_f(y, k[63:32], k[31:0], s);
        end
        return {y, z};
    endfunction

    function automatic logic [63:0] ref_dec(logic [63:0] d, logic [127:0] k);
        logic [31:0] y, z, s;
        y = d[63:32]; z = d[31:0]; s = 32'hC6EF_3720;
        for (int i = 0; i < 32; i++) begin
            z = z - ref_f(y, k[63:32], k[31:0], s);
            y = y - ref_f(z, k[127:96], k[95:64], s);
            s = s - 32'h9E37_79B9;
        end
        return {y, z};
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drives one operation; scramble changes the operands right after acceptance.
    task automatic run_op(input logic [127:0] k, input logic [63:0] d, input logic dec,
                          input bit scramble, output logic [63:0] res, output int lat);
        @(negedge clk);
        key_i = k; data_i = d; decrypt_i = dec; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        lat = 1;
        if (scramble) begin
            key_i = ~k; data_i = ~d; decrypt_i = ~dec;
        end
        while (!done_o && lat < 100) begin
            @(negedge clk);
            lat++;
        end
        res = result_o;
    endtask

    initial begin
        logic [63:0] res, res2, hold;
        int lat;

        repeat (3) @(negedge clk);
        // R1: reset state
        check(result_o == 64'h0, "R1 result in reset", result_o, 64'h0);
        check(done_o == 1'b0, "R1 done in reset", {63'h0, done_o}, 64'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(result_o == 64'h0 && !done_o, "R1 after release", result_o, 64'h0);

        // R4: known answer, R5 latency
        run_op('0, '0, 1'b0, 1'b0, res, lat);
        check(res == 64'h41EA_3A0A_94BA_A940, "R4 zero vector", res, 64'h41EA_3A0A_94BA_A940);
        check(lat == EXP_LAT, "R5 latency", 64'(lat), 64'(EXP_LAT));
        @(negedge clk);
        check(done_o == 1'b0, "R5 done width", {63'h0, done_o}, 64'h0);

        // R3: round trip of the known answer
        run_op('0, res, 1'b1, 1'b0, res2, lat);
        check(res2 == 64'h0, "R3 zero round trip", res2, 64'h0);

        // R2 / R3 / R9 table walk (entry 2 is all-ones for R9)
        for (int i = 0; i < N_VEC; i++) begin
            logic [63:0] exp;
            exp = TV_DEC[i] ? ref_dec(TV_DATA[i], TV_KEY[i]) : ref_enc(TV_DATA[i], TV_KEY[i]);
            run_op(TV_KEY[i], TV_DATA[i], TV_DEC[i], 1'b0, res, lat);
            check(res == exp, TV_DEC[i] ? "R3 table decrypt" : "R2 R9 table encrypt", res, exp);
            run_op(TV_KEY[i], res, ~TV_DEC[i], 1'b0, res2, lat);
            check(res2 == TV_DATA[i], "R3 inverse", res2, TV_DATA[i]);
        end

        // R6: operands changed after acceptance
        run_op(TV_KEY[1], TV_DATA[4], 1'b0, 1'b1, res, lat);
        check(res == ref_enc(TV_DATA[4], TV_KEY[1]), "R6 latched operands", res,
              ref_enc(TV_DATA[4], TV_KEY[1]));

        // R7: start pulse mid-run is ignored
        @(negedge clk);
        key_i = TV_KEY[5]; data_i = TV_DATA[3]; decrypt_i = 1'b0; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        lat = 1;
        repeat (9) begin @(negedge clk); lat++; end
        key_i = TV_KEY[2]; data_i = TV_DATA[0]; decrypt_i = 1'b1; start_i = 1'b1;
        @(negedge clk); lat++;
        start_i = 1'b0;
        while (!done_o && lat < 100) begin @(negedge clk); lat++; end
        check(lat == EXP_LAT, "R7 completion time", 64'(lat), 64'(EXP_LAT));
        check(result_o == ref_enc(TV_DATA[3], TV_KEY[5]), "R7 operands kept", result_o,
              ref_enc(TV_DATA[3], TV_KEY[5]));

        // R8: hold while idle with changing inputs
        hold = result_o;
        repeat (6) begin
            @(negedge clk);
            key_i = ~key_i; data_i = data_i + 64'h1357; decrypt_i = ~decrypt_i;
        end
        check(result_o == hold, "R8 idle hold", result_o, hold);
        check(done_o == 1'b0, "R8 no done while idle", {63'h0, done_o}, 64'h0);

        if (!finished) begin
            finished = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=expired expected=completion");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule